// File: doc/BRIEF.md
# Frame Start and Odd/Even Controller

This block sits between a panel timing controller and the gate-drive level shifters. It receives a frame-start strobe, a gate timing level, an alternation toggle and a discharge request. All four are asynchronous to the system clock, so it synchronizes them and works out their edges. The frame-start strobe goes to one of two outputs, chosen by the gate timing level. When the gate level is low, the strobe appears on the vertical-start output. When the gate level is high, it appears on the row-reset output instead.

The block also drives a complementary odd/even pair. While the toggle input is high, both lines are held low. When the toggle falls, each line takes the opposite of the value it had before the pulse, so the pulse width becomes the dead time.

At every rising edge of the frame strobe, the toggle level is sampled. If it is high, the block enters a protective abnormal mode. If it is low, the block returns to normal mode. A discharge request also forces abnormal mode for as long as it is held. In abnormal mode the strobe outputs stay low and the pair sits in its power-up state. The abnormal indication is exported so that the downstream clock sequencer can return to its start-of-frame state.

Top module: `frame_start_ctrl`

## Requirements
- R1: In normal mode, `vstart_o` is high exactly when the synchronized frame strobe is high and the synchronized gate level is low.
- R2: In normal mode, `row_reset_o` is high exactly when the synchronized frame strobe is high and the synchronized gate level is high. `vstart_o` and `row_reset_o` are never high together.
- R3: A rising edge of the frame strobe that finds the toggle input high sets `abnormal_o` to 1. Toggle activity between frame-strobe edges never changes the mode.
- R4: In abnormal mode, a rising edge of the frame strobe that finds the toggle low returns the block to normal mode. A rising edge that finds the toggle high keeps it abnormal.
- R5: While `abnormal_o` is 1, `vstart_o` and `row_reset_o` are both 0, whatever the strobe and gate levels are.
- R6: After reset, and throughout abnormal mode, the pair is in its power-up state: `even_o`=1 and `odd_o`=0. Toggle pulses during abnormal mode leave the pair unchanged.
- R7: In normal mode, a rising edge of the toggle input drives `odd_o` and `even_o` both to 0, and they stay at 0 while the toggle stays high.
- R8: In normal mode, a falling edge of the toggle input that ends a dead time sets each pair output to the inverse of the value it held just before that dead time began.
- R9: While the discharge request is high, `abnormal_o` is 1 and the abnormal-mode output forcing applies. When the request drops and no frame-start decision has set the mode, normal operation resumes at once.
- R10: Every output is registered. A change on any input becomes visible at the outputs after the third rising clock edge (two synchronizer stages plus one output register) and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe_i | input | 1 | Frame-start strobe, asynchronous |
| gate_lvl_i | input | 1 | Gate timing level that steers the strobe, asynchronous |
| toggle_i | input | 1 | Odd/even alternation pulse and abnormal-mode sample, asynchronous |
| dschg_req_i | input | 1 | Discharge request from the external comparator, asynchronous |
| vstart_o | output | 1 | Vertical-start output |
| row_reset_o | output | 1 | Row-reset output |
| odd_o | output | 1 | Odd drive line |
| even_o | output | 1 | Even drive line |
| abnormal_o | output | 1 | Abnormal mode indication for the clock sequencer |

## Verification
The hardest situation to reach is entering abnormal mode while a dead time is in progress. The pair must first be left in its odd-high phase. The toggle is then raised so that both lines are low. Only after that does the frame strobe rise, while the toggle is still high. At that point the even line must jump from the dead-time low straight to its forced high. The odd line must stay low, and the later falling edge of the toggle must not restore the inverted pair.

The stimulus builds this order step by step, waiting the full synchronizer latency between steps. It then holds the toggle through a second frame edge to confirm the block stays abnormal. The exit is checked on a frame edge with the toggle low, where the vertical-start output must rise in the same cycle as the abnormal indication falls.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    // Synchronized control inputs, carried as one packed word
    typedef struct packed {
        logic strobe;
        logic gate;
        logic toggle;
        logic dschg;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic odd;
        logic even;
    } pair_t;

    localparam pair_t PAIR_PWRUP = '{odd: 1'b0, even: 1'b1};
    localparam pair_t PAIR_DEAD  = '{odd: 1'b0, even: 1'b0};

    typedef enum logic {
        MODE_NORMAL   = 1'b0,
        MODE_ABNORMAL = 1'b1
    } mode_e;

    function automatic pair_t invert_pair(input pair_t p);
        pair_t r;
        r.odd  = ~p.odd;
        r.even = ~p.even;
        return r;
    endfunction

    function automatic mode_e mode_decide(input mode_e cur, input logic frame_edge,
                                          input logic toggle_lvl);
        mode_e r;
        r = cur;
        if (frame_edge) begin
            r = toggle_lvl ? MODE_ABNORMAL : MODE_NORMAL;
        end
        return r;
    endfunction

endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/fsc_edge.sv
module fsc_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign rise_o[i] = lvl_i[i] & ~prev_q[i];
            assign fall_o[i] = ~lvl_i[i] & prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/fsc_mode.sv
module fsc_mode
    import fsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_rise_i,
    input  logic toggle_lvl_i,
    input  logic dschg_lvl_i,
    output logic abn_eff_o
);
    mode_e mode_q;
    mode_e mode_d;

    always_comb begin
        mode_d    = mode_decide(mode_q, frame_rise_i, toggle_lvl_i);
        abn_eff_o = (mode_d == MODE_ABNORMAL) | dschg_lvl_i;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_NORMAL;
        else     mode_q <= mode_d;
    end

    // Mode moves only on frame-strobe rising edges
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_rise_i |=> $stable(mode_q)) else $error("mode changed off frame edge"); // R3
    AST_MODE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        frame_rise_i && toggle_lvl_i |=> mode_q == MODE_ABNORMAL) else $error("no abnormal entry"); // R3
    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (rst)
        frame_rise_i && !toggle_lvl_i |=> mode_q == MODE_NORMAL) else $error("no abnormal exit"); // R4
endmodule

// File: rtl/fsc_pair.sv
module fsc_pair
    import fsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  abn_eff_i,
    input  logic  tog_rise_i,
    input  logic  tog_fall_i,
    output pair_t pair_o
);
    pair_t pair_q;
    pair_t saved_q;
    logic  dead_q;

    always_ff @(posedge clk) begin
        if (rst || abn_eff_i) begin
            pair_q  <= PAIR_PWRUP;
            saved_q <= PAIR_PWRUP;
            dead_q  <= 1'b0;
        end else if (tog_rise_i) begin
            saved_q <= pair_q;
            pair_q  <= PAIR_DEAD;
            dead_q  <= 1'b1;
        end else if (tog_fall_i && dead_q) begin
            pair_q  <= invert_pair(saved_q);
            dead_q  <= 1'b0;
        end
    end

    assign pair_o = pair_q;

    AST_DEAD_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
        tog_rise_i && !abn_eff_i |=> pair_q == PAIR_DEAD) else $error("dead time missing"); // R7
    AST_PAIR_NOT_BOTH_HIGH: assert property (@(posedge clk) disable iff (rst)
        !(pair_q.odd && pair_q.even)) else $error("odd and even both high"); // R8
endmodule

// File: rtl/frame_start_ctrl.sv
module frame_start_ctrl
    import fsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_strobe_i,
    input  logic gate_lvl_i,
    input  logic toggle_i,
    input  logic dschg_req_i,
    output logic vstart_o,
    output logic row_reset_o,
    output logic odd_o,
    output logic even_o,
    output logic abnormal_o
);
    localparam int EDGE_W = 2;
    localparam int E_TOG  = 0;
    localparam int E_STR  = 1;

    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    logic [CTL_W-1:0]  ctl_vec;
    logic [EDGE_W-1:0] rise;
    logic [EDGE_W-1:0] fall;
    logic              abn_eff;
    pair_t             pair;

    assign ctl_raw = '{strobe: frame_strobe_i, gate: gate_lvl_i,
                       toggle: toggle_i, dschg: dschg_req_i};

    fsc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ctl_raw),
        .q_o (ctl_vec)
    );
    assign ctl_s = ctl_t'(ctl_vec);

    fsc_edge #(.W(EDGE_W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  ({ctl_s.strobe, ctl_s.toggle}),
        .rise_o (rise),
        .fall_o (fall)
    );

    fsc_mode u_mode (
        .clk          (clk),
        .rst          (rst),
        .frame_rise_i (rise[E_STR]),
        .toggle_lvl_i (ctl_s.toggle),
        .dschg_lvl_i  (ctl_s.dschg),
        .abn_eff_o    (abn_eff)
    );

    fsc_pair u_pair (
        .clk        (clk),
        .rst        (rst),
        .abn_eff_i  (abn_eff),
        .tog_rise_i (rise[E_TOG]),
        .tog_fall_i (fall[E_TOG]),
        .pair_o     (pair)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vstart_o    <= 1'b0;
            row_reset_o <= 1'b0;
            abnormal_o  <= 1'b0;
        end else begin
            vstart_o    <= ctl_s.strobe & ~ctl_s.gate & ~abn_eff;
            row_reset_o <= ctl_s.strobe &  ctl_s.gate & ~abn_eff;
            abnormal_o  <= abn_eff;
        end
    end

    assign odd_o  = pair.odd;
    assign even_o = pair.even;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(vstart_o && row_reset_o)) else $error("both strobe outputs high"); // R2
    AST_ABN_QUIET: assert property (@(posedge clk) disable iff (rst)
        abnormal_o |-> !vstart_o && !row_reset_o) else $error("strobe out in abnormal"); // R5
    AST_ABN_PAIR: assert property (@(posedge clk) disable iff (rst)
        abnormal_o |-> even_o && !odd_o) else $error("pair not forced"); // R6
    AST_STROBE_DROP: assert property (@(posedge clk) disable iff (rst)
        fall[E_STR] |=> !vstart_o && !row_reset_o) else $error("strobe out stuck"); // R1
    AST_DSCHG_ABN: assert property (@(posedge clk) disable iff (rst)
        ctl_s.dschg |=> abnormal_o) else $error("discharge not abnormal"); // R9
endmodule

// File: tb/frame_start_ctrl_tb.sv
module frame_start_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe = 1'b0, gate = 1'b0, tog = 1'b0, dschg = 1'b0;
    logic vstart, rrst, odd, even, abn;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frame_start_ctrl u_dut (
        .clk            (clk),
        .rst            (rst),
        .frame_strobe_i (strobe),
        .gate_lvl_i     (gate),
        .toggle_i       (tog),
        .dschg_req_i    (dschg),
        .vstart_o       (vstart),
        .row_reset_o    (rrst),
        .odd_o          (odd),
        .even_o         (even),
        .abnormal_o     (abn)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b exp %0b", req, got, exp);
        end
    endtask

    task automatic t_reset();
        chk("R6 reset even", even, 1'b1);
        chk("R6 reset odd", odd, 1'b0);
        chk("R1 reset vstart", vstart, 1'b0);
        chk("R2 reset row_reset", rrst, 1'b0);
        chk("R3 reset abnormal", abn, 1'b0);
    endtask

    task automatic t_vstart();
        gate = 1'b0; strobe = 1'b1;
        step(2);
        chk("R10 vstart not before third edge", vstart, 1'b0);
        step(1);
        chk("R1 vstart high", vstart, 1'b1);
        chk("R2 row_reset low with gate low", rrst, 1'b0);
        strobe = 1'b0;
        step(3);
        chk("R1 vstart low after strobe", vstart, 1'b0);
    endtask

    task automatic t_rowreset();
        gate = 1'b1; step(3);
        strobe = 1'b1; step(3);
        chk("R2 row_reset high", rrst, 1'b1);
        chk("R1 vstart low with gate high", vstart, 1'b0);
        gate = 1'b0; step(3);
        chk("R1 vstart follows gate low", vstart, 1'b1);
        chk("R2 row_reset follows gate low", rrst, 1'b0);
        strobe = 1'b0; step(3);
        chk("R2 row_reset low", rrst, 1'b0);
    endtask

    task automatic t_oddeven();
        tog = 1'b1; step(3);
        chk("R7 odd low in dead time", odd, 1'b0);
        chk("R7 even low in dead time", even, 1'b0);
        step(10);
        chk("R7 even held low while toggle high", even, 1'b0);
        tog = 1'b0; step(3);
        chk("R8 odd inverted", odd, 1'b1);
        chk("R8 even inverted", even, 1'b0);
        chk("R3 toggle pulse leaves mode normal", abn, 1'b0);
        tog = 1'b1; step(3);
        chk("R7 both low second pulse", odd | even, 1'b0);
        tog = 1'b0; step(3);
        chk("R8 odd back low", odd, 1'b0);
        chk("R8 even back high", even, 1'b1);
    endtask

    task automatic t_abnormal();
        tog = 1'b1; step(3);
        tog = 1'b0; step(3);
        chk("R8 odd phase set up", odd, 1'b1);
        tog = 1'b1; step(3);
        chk("R7 dead time before frame edge", even, 1'b0);
        gate = 1'b0; strobe = 1'b1; step(3);
        chk("R3 abnormal entered", abn, 1'b1);
        chk("R5 vstart forced low", vstart, 1'b0);
        chk("R6 even forced high", even, 1'b1);
        chk("R6 odd forced low", odd, 1'b0);
        strobe = 1'b0; tog = 1'b0; step(3);
        chk("R6 toggle fall ignored odd", odd, 1'b0);
        chk("R3 stays abnormal off frame edge", abn, 1'b1);
        tog = 1'b1; step(3);
        chk("R6 toggle rise ignored even", even, 1'b1);
        gate = 1'b1; strobe = 1'b1; step(3);
        chk("R4 frame edge with toggle high keeps abnormal", abn, 1'b1);
        chk("R5 row_reset forced low", rrst, 1'b0);
        strobe = 1'b0; tog = 1'b0; gate = 1'b0; step(3);
        strobe = 1'b1; step(3);
        chk("R4 abnormal left", abn, 1'b0);
        chk("R4 vstart on exit edge", vstart, 1'b1);
        chk("R6 pair at power-up after exit", even & ~odd, 1'b1);
        strobe = 1'b0; step(3);
    endtask

    task automatic t_discharge();
        dschg = 1'b1; step(3);
        chk("R9 discharge sets abnormal", abn, 1'b1);
        strobe = 1'b1; step(3);
        chk("R9 vstart blocked by discharge", vstart, 1'b0);
        chk("R9 even forced high", even, 1'b1);
        dschg = 1'b0; step(3);
        chk("R9 abnormal cleared after request", abn, 1'b0);
        chk("R9 vstart resumes", vstart, 1'b1);
        strobe = 1'b0; step(3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_vstart();
        t_rowreset();
        t_oddeven();
        t_abnormal();
        t_discharge();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule